// File: doc/BRIEF.md
# Tagged-Token Operand Matching Stage

This block is one pipeline stage of a tagged-token dataflow processor. Each incoming token brings a frame pointer, an instruction pointer, a port flag saying whether it is the left or right operand, and a data word. The token also brings two fields from the already decoded instruction: a slot offset and a matching mode. The stage turns these into a slot address inside an activation frame. It then looks at a presence bit kept for that slot. From the mode and that bit it decides one of two outcomes. Either the operand is parked in the slot and nothing goes downstream, or a pair of operands is handed to the execute stage.

The frame store and its presence bits live inside the block. An operator can have only one partner waiting, so each two-input operator owns one slot. Five matching behaviours are offered, chosen per instruction:
- plain unary pass-through;
- normal rendezvous;
- sticky rendezvous, where the parked value serves many partners;
- exchange, which swaps the slot contents;
- imperative plain read or write.

Tokens enter with a valid/ready handshake, one per cycle. Results leave through a registered valid/ready output.

Top module: `mt_operand_match`

## Requirements
- R1: After reset, `out_valid` is 0, `in_ready` is 1 and every presence bit is clear.
- R2: A token with `in_mode` 0 (unary) fires without touching the frame, with `out_left` = data and `out_right` = 0. Codes 5, 6 and 7 behave the same way.
- R3: With `in_mode` 1 (normal) and the slot's presence bit clear, the data is stored, the bit is set and no output is produced.
- R4: With `in_mode` 1 and the bit set, the stage fires and clears the bit. A token with `in_port` 0 (left) gives `out_left` = data and `out_right` = stored value. A token with `in_port` 1 (right) gives `out_left` = stored value and `out_right` = data.
- R5: The slot address is (`in_fp` + `in_offset`) mod 64 when `in_rel` = 1, and `in_offset` alone when `in_rel` = 0.
- R6: With `in_mode` 2 (sticky), an empty slot behaves as in R3. A full slot fires in port order, as in R4, but keeps both its value and its presence bit.
- R7: With `in_mode` 3 (exchange), the stage always fires with `out_left` = old slot value and `out_right` = data. It writes data into the slot and sets the bit.
- R8: With `in_mode` 4 (imperative), `in_imp_wr` = 1 writes data into the slot with no output. `in_imp_wr` = 0 fires with `out_left` = slot value and `out_right` = data. Neither case changes the presence bit.
- R9: Tokens aimed at the same slot on consecutive cycles each see the slot state left by the token before them.
- R10: `in_ready` = !`out_valid` || `out_ready`, so one token can be accepted per cycle. While `out_valid` = 1 and `out_ready` = 0, the output holds its value.
- R11: A fired result carries `out_ip` and `out_fp` from the token that caused the firing. It appears one cycle after that token is accepted, or later under back-pressure.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Token offered |
| in_ready | output | 1 | Token taken this cycle |
| in_fp | input | 6 | Frame pointer |
| in_ip | input | 8 | Instruction pointer |
| in_port | input | 1 | 0 left operand, 1 right operand |
| in_data | input | 16 | Operand value |
| in_offset | input | 6 | Instruction slot offset |
| in_rel | input | 1 | 1 frame-relative, 0 absolute slot |
| in_mode | input | 3 | Matching mode code |
| in_imp_wr | input | 1 | Imperative: 1 write, 0 read |
| out_valid | output | 1 | Operand pair available |
| out_ready | input | 1 | Downstream accepts pair |
| out_fp | output | 6 | Frame pointer of firing token |
| out_ip | output | 8 | Instruction pointer of firing token |
| out_left | output | 16 | Left operand |
| out_right | output | 16 | Right operand |

## Verification
The hardest case to reach is a read-modify-write of one slot under two conditions at once:
- successive tokens reach that slot on back-to-back cycles;
- the output is stalled part of the time.

In that case the decision for a token depends on a write made only one cycle earlier, and that cycle itself may have been frozen. The stimulus first sends directed bursts of normal and sticky tokens to a single slot on consecutive cycles. It then runs a long random phase: slot addresses are folded onto a handful of slots, and `out_ready` is randomly dropped. The scoreboard's own model of the presence bits and slot contents predicts every firing and every silent store.

// File: rtl/mt_pkg.sv
package mt_pkg;
  typedef enum logic [2:0] {
    MODE_UNARY  = 3'd0,
    MODE_NORMAL = 3'd1,
    MODE_STICKY = 3'd2,
    MODE_EXCH   = 3'd3,
    MODE_IMPER  = 3'd4
  } match_mode_e;
endpackage

// File: rtl/mt_slot_addr.sv
module mt_slot_addr #(
  parameter int FP_W   = 6,
  parameter int OFF_W  = 6,
  parameter int ADDR_W = 6
) (
  input  logic [FP_W-1:0]   fp_i,
  input  logic [OFF_W-1:0]  off_i,
  input  logic              rel_i,
  output logic [ADDR_W-1:0] slot_o
);
  logic [ADDR_W-1:0] rel_slot;
  logic [ADDR_W-1:0] abs_slot;

  // Sum wraps modulo the frame store size.
  assign rel_slot = ADDR_W'(fp_i) + ADDR_W'(off_i);
  assign abs_slot = ADDR_W'(off_i);

  always_comb begin
    if (rel_i) slot_o = rel_slot;
    else       slot_o = abs_slot;
  end
endmodule

// File: rtl/mt_match_rule.sv
module mt_match_rule
  import mt_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic [2:0]        mode_i,
  input  logic              port_i,
  input  logic              imp_wr_i,
  input  logic              pres_i,
  input  logic [DATA_W-1:0] slot_i,
  input  logic [DATA_W-1:0] tok_i,
  output logic              fire_o,
  output logic              mem_we_o,
  output logic              pb_we_o,
  output logic              pb_d_o,
  output logic [DATA_W-1:0] left_o,
  output logic [DATA_W-1:0] right_o
);
  logic [DATA_W-1:0] ord_left;
  logic [DATA_W-1:0] ord_right;

  // Port-ordered pairing of the stored value with the arriving one.
  always_comb begin
    if (port_i) begin
      ord_left  = slot_i;
      ord_right = tok_i;
    end else begin
      ord_left  = tok_i;
      ord_right = slot_i;
    end
  end

  always_comb begin
    fire_o   = 1'b0;
    mem_we_o = 1'b0;
    pb_we_o  = 1'b0;
    pb_d_o   = 1'b0;
    left_o   = tok_i;
    right_o  = '0;
    case (match_mode_e'(mode_i))
      MODE_NORMAL: begin
        pb_we_o = 1'b1;
        if (pres_i) begin
          fire_o  = 1'b1;
          pb_d_o  = 1'b0;
          left_o  = ord_left;
          right_o = ord_right;
        end else begin
          mem_we_o = 1'b1;
          pb_d_o   = 1'b1;
        end
      end
      MODE_STICKY: begin
        if (pres_i) begin
          fire_o  = 1'b1;
          left_o  = ord_left;
          right_o = ord_right;
        end else begin
          mem_we_o = 1'b1;
          pb_we_o  = 1'b1;
          pb_d_o   = 1'b1;
        end
      end
      MODE_EXCH: begin
        fire_o   = 1'b1;
        mem_we_o = 1'b1;
        pb_we_o  = 1'b1;
        pb_d_o   = 1'b1;
        left_o   = slot_i;
        right_o  = tok_i;
      end
      MODE_IMPER: begin
        if (imp_wr_i) begin
          mem_we_o = 1'b1;
        end else begin
          fire_o  = 1'b1;
          left_o  = slot_i;
          right_o = tok_i;
        end
      end
      default: begin
        fire_o  = 1'b1;
        left_o  = tok_i;
        right_o = '0;
      end
    endcase
  end
endmodule

// File: rtl/mt_frame_store.sv
module mt_frame_store #(
  parameter int SLOTS  = 64,
  parameter int DATA_W = 16,
  localparam int ADDR_W = $clog2(SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              pres_o,
  output logic [DATA_W-1:0] data_o,
  input  logic              mem_we_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              pb_we_i,
  input  logic              pb_d_i,
  output logic [SLOTS-1:0]  pres_vec_o
);
  logic [DATA_W-1:0] mem_q [SLOTS];
  logic [SLOTS-1:0]  pres_q;
  logic [SLOTS-1:0]  pres_d;

  // Same-cycle read; a write lands at the edge, before the next token reads.
  assign pres_o     = pres_q[addr_i];
  assign data_o     = mem_q[addr_i];
  assign pres_vec_o = pres_q;

  always_comb begin
    pres_d = pres_q;
    if (pb_we_i) pres_d[addr_i] = pb_d_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pres_q <= '0;
    else if (pb_we_i) pres_q <= pres_d;
  end

  always_ff @(posedge clk) begin
    if (mem_we_i) mem_q[addr_i] <= wdata_i;
  end
endmodule

// File: rtl/mt_operand_match.sv
module mt_operand_match
  import mt_pkg::*;
#(
  parameter int FP_W   = 6,
  parameter int IP_W   = 8,
  parameter int OFF_W  = 6,
  parameter int DATA_W = 16,
  parameter int SLOTS  = 64,
  localparam int ADDR_W = $clog2(SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [FP_W-1:0]   in_fp,
  input  logic [IP_W-1:0]   in_ip,
  input  logic              in_port,
  input  logic [DATA_W-1:0] in_data,
  input  logic [OFF_W-1:0]  in_offset,
  input  logic              in_rel,
  input  logic [2:0]        in_mode,
  input  logic              in_imp_wr,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [FP_W-1:0]   out_fp,
  output logic [IP_W-1:0]   out_ip,
  output logic [DATA_W-1:0] out_left,
  output logic [DATA_W-1:0] out_right
);
  // Stage A: slot address registered with the token
  logic              adv;
  logic              a_valid_q;
  logic [ADDR_W-1:0] a_slot_q;
  logic [2:0]        a_mode_q;
  logic              a_port_q;
  logic              a_impw_q;
  logic [DATA_W-1:0] a_data_q;
  logic [IP_W-1:0]   a_ip_q;
  logic [FP_W-1:0]   a_fp_q;
  logic [ADDR_W-1:0] slot_d;

  // Stage B: match against the frame store
  logic              act;
  logic              rd_pres;
  logic [DATA_W-1:0] rd_data;
  logic              r_fire, r_mem_we, r_pb_we, r_pb_d;
  logic [DATA_W-1:0] r_left, r_right;
  logic [SLOTS-1:0]  pres_vec;
  logic              out_valid_d;

  assign adv      = !out_valid || out_ready;
  assign in_ready = adv;
  assign act      = a_valid_q && adv;

  mt_slot_addr #(.FP_W(FP_W), .OFF_W(OFF_W), .ADDR_W(ADDR_W)) u_addr (
    .fp_i   (in_fp),
    .off_i  (in_offset),
    .rel_i  (in_rel),
    .slot_o (slot_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) a_valid_q <= 1'b0;
    else if (adv) a_valid_q <= in_valid;
  end

  always_ff @(posedge clk) begin
    if (adv && in_valid) begin
      a_slot_q <= slot_d;
      a_mode_q <= in_mode;
      a_port_q <= in_port;
      a_impw_q <= in_imp_wr;
      a_data_q <= in_data;
      a_ip_q   <= in_ip;
      a_fp_q   <= in_fp;
    end
  end

  mt_frame_store #(.SLOTS(SLOTS), .DATA_W(DATA_W)) u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .addr_i     (a_slot_q),
    .pres_o     (rd_pres),
    .data_o     (rd_data),
    .mem_we_i   (act && r_mem_we),
    .wdata_i    (a_data_q),
    .pb_we_i    (act && r_pb_we),
    .pb_d_i     (r_pb_d),
    .pres_vec_o (pres_vec)
  );

  mt_match_rule #(.DATA_W(DATA_W)) u_rule (
    .mode_i   (a_mode_q),
    .port_i   (a_port_q),
    .imp_wr_i (a_impw_q),
    .pres_i   (rd_pres),
    .slot_i   (rd_data),
    .tok_i    (a_data_q),
    .fire_o   (r_fire),
    .mem_we_o (r_mem_we),
    .pb_we_o  (r_pb_we),
    .pb_d_o   (r_pb_d),
    .left_o   (r_left),
    .right_o  (r_right)
  );

  assign out_valid_d = act && r_fire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_valid <= 1'b0;
    else if (adv) out_valid <= out_valid_d;
  end

  always_ff @(posedge clk) begin
    if (out_valid_d) begin
      out_left  <= r_left;
      out_right <= r_right;
      out_ip    <= a_ip_q;
      out_fp    <= a_fp_q;
    end
  end

  // Assertions
  a_r2_unary_fires: assert property (@(posedge clk) disable iff (!rst_n)
    act && a_mode_q == MODE_UNARY |=> out_valid);
  a_r3_normal_store_inhibits: assert property (@(posedge clk) disable iff (!rst_n)
    act && a_mode_q == MODE_NORMAL && !rd_pres |=> !out_valid && pres_vec[$past(a_slot_q)]);
  a_r4_normal_match_clears: assert property (@(posedge clk) disable iff (!rst_n)
    act && a_mode_q == MODE_NORMAL && rd_pres |=> out_valid && !pres_vec[$past(a_slot_q)]);
  a_r6_sticky_keeps_bit: assert property (@(posedge clk) disable iff (!rst_n)
    act && a_mode_q == MODE_STICKY && rd_pres |=> out_valid && pres_vec[$past(a_slot_q)]);
  a_r8_imperative_bit_unchanged: assert property (@(posedge clk) disable iff (!rst_n)
    act && a_mode_q == MODE_IMPER |=> pres_vec[$past(a_slot_q)] == $past(rd_pres));
  a_r10_output_held: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_left) && $stable(out_right) && $stable(out_ip));
endmodule

// File: tb/mt_operand_match_tb.sv
module mt_operand_match_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_ready;
  logic [5:0] in_fp = '0, in_offset = '0;
  logic [7:0] in_ip = '0;
  logic in_port = 1'b0, in_rel = 1'b0, in_imp_wr = 1'b0;
  logic [15:0] in_data = '0;
  logic [2:0] in_mode = '0;
  logic out_valid, out_ready = 1'b1;
  logic [5:0] out_fp;
  logic [7:0] out_ip;
  logic [15:0] out_left, out_right;

  int total = 0, bad = 0;
  bit rand_ready = 1'b0;
  bit done = 1'b0;

  // Scoreboard model and queues
  bit         m_pres [64];
  bit         m_wr   [64];
  logic [15:0] m_mem [64];
  logic [15:0] q_l[$], q_r[$];
  logic [7:0]  q_ip[$];
  logic [5:0]  q_fp[$];
  string       q_tag[$];

  always #4 clk = ~clk; // 125 MHz

  mt_operand_match u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_fp(in_fp), .in_ip(in_ip), .in_port(in_port), .in_data(in_data),
    .in_offset(in_offset), .in_rel(in_rel), .in_mode(in_mode), .in_imp_wr(in_imp_wr),
    .out_valid(out_valid), .out_ready(out_ready), .out_fp(out_fp), .out_ip(out_ip),
    .out_left(out_left), .out_right(out_right));

  always @(posedge clk) begin
    #1;
    out_ready = rand_ready ? 1'($urandom_range(0, 1)) : 1'b1;
  end

  function automatic logic [5:0] slot_of(logic rel, logic [5:0] fp, logic [5:0] off);
    return rel ? 6'(fp + off) : off; // R5
  endfunction

  task automatic push(logic [15:0] l, logic [15:0] r, logic [7:0] ip, logic [5:0] fp, string tag);
    q_l.push_back(l); q_r.push_back(r); q_ip.push_back(ip); q_fp.push_back(fp); q_tag.push_back(tag);
  endtask

  task automatic send(logic [2:0] m, logic rel, logic iw, logic pt, logic [5:0] fp,
                      logic [7:0] ip, logic [5:0] off, logic [15:0] d, string tag);
    logic [5:0] s;
    @(negedge clk);
    in_valid = 1'b1; in_mode = m; in_rel = rel; in_imp_wr = iw; in_port = pt;
    in_fp = fp; in_ip = ip; in_offset = off; in_data = d;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    #1 in_valid = 1'b0;
    s = slot_of(rel, fp, off);
    case (m)
      3'd1, 3'd2: begin
        if (!m_pres[s]) begin
          m_pres[s] = 1'b1; m_mem[s] = d; m_wr[s] = 1'b1;
        end else begin
          if (pt) push(m_mem[s], d, ip, fp, tag);
          else    push(d, m_mem[s], ip, fp, tag);
          if (m == 3'd1) m_pres[s] = 1'b0;
        end
      end
      3'd3: begin
        push(m_mem[s], d, ip, fp, tag);
        m_mem[s] = d; m_pres[s] = 1'b1; m_wr[s] = 1'b1;
      end
      3'd4: begin
        if (iw) begin m_mem[s] = d; m_wr[s] = 1'b1; end
        else push(m_mem[s], d, ip, fp, tag);
      end
      default: push(d, 16'h0, ip, fp, tag);
    endcase
  endtask

  task automatic check(bit ok, string tag, string what, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // Monitor: pops the expected pair when a transfer completes at the next edge
  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready) begin
      if (q_l.size() == 0) begin
        check(1'b0, "R3", "unexpected output left", int'(out_left), 0);
      end else begin
        string t;
        logic [15:0] el, er;
        logic [7:0] eip;
        logic [5:0] efp;
        t = q_tag.pop_front(); el = q_l.pop_front(); er = q_r.pop_front();
        eip = q_ip.pop_front(); efp = q_fp.pop_front();
        check(out_left == el, t, "left", int'(out_left), int'(el));
        check(out_right == er, t, "right", int'(out_right), int'(er));
        check(out_ip == eip && out_fp == efp, {t, "/R11"}, "ip,fp",
              int'({out_ip, out_fp}), int'({eip, efp}));
      end
    end
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    for (int i = 0; i < 64; i++) begin m_pres[i] = 1'b0; m_wr[i] = 1'b0; m_mem[i] = '0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(out_valid == 1'b0, "R1", "out_valid in reset", int'(out_valid), 0);
    check(in_ready == 1'b1, "R1", "in_ready in reset", int'(in_ready), 1);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0 && in_ready == 1'b1, "R1", "after reset", int'({out_valid, in_ready}), 1);

    // R2 unary and unused codes
    send(3'd0, 0, 0, 0, 6'd1, 8'h10, 6'd3, 16'h1234, "R2");
    send(3'd5, 0, 0, 1, 6'd2, 8'h11, 6'd3, 16'h2222, "R2");
    send(3'd7, 1, 0, 0, 6'd3, 8'h12, 6'd4, 16'h3333, "R2");
    // R3/R4 normal: left first, then right; and reversed on another slot
    send(3'd1, 0, 0, 0, 6'd0, 8'h20, 6'd8, 16'hAAAA, "R3");
    send(3'd1, 0, 0, 1, 6'd0, 8'h21, 6'd8, 16'hBBBB, "R4");
    send(3'd1, 0, 0, 1, 6'd0, 8'h22, 6'd9, 16'hCCCC, "R3");
    send(3'd1, 0, 0, 0, 6'd0, 8'h23, 6'd9, 16'hDDDD, "R4");
    // R5 relative vs absolute reach the same slot, plus wrap
    send(3'd1, 1, 0, 0, 6'd10, 8'h30, 6'd5, 16'h0101, "R5");
    send(3'd1, 0, 0, 1, 6'd0, 8'h31, 6'd15, 16'h0202, "R5");
    send(3'd1, 1, 0, 1, 6'd60, 8'h32, 6'd10, 16'h0303, "R5");
    send(3'd1, 0, 0, 0, 6'd0, 8'h33, 6'd6, 16'h0404, "R5");
    // R6 sticky: one stored, three partners
    send(3'd2, 0, 0, 0, 6'd0, 8'h40, 6'd20, 16'h5000, "R6");
    send(3'd2, 0, 0, 1, 6'd0, 8'h41, 6'd20, 16'h5001, "R6");
    send(3'd2, 0, 0, 1, 6'd0, 8'h42, 6'd20, 16'h5002, "R6");
    send(3'd2, 0, 0, 0, 6'd0, 8'h43, 6'd20, 16'h5003, "R6");
    // R8 imperative write, read, bit untouched
    send(3'd4, 0, 1, 0, 6'd0, 8'h50, 6'd30, 16'h7777, "R8");
    send(3'd4, 0, 0, 0, 6'd0, 8'h51, 6'd30, 16'h0001, "R8");
    send(3'd1, 0, 0, 0, 6'd0, 8'h52, 6'd30, 16'h8888, "R8");
    send(3'd1, 0, 0, 1, 6'd0, 8'h53, 6'd30, 16'h9999, "R8");
    // R7 exchange chain
    send(3'd4, 0, 1, 0, 6'd0, 8'h60, 6'd31, 16'hA000, "R7");
    send(3'd3, 0, 0, 0, 6'd0, 8'h61, 6'd31, 16'hB000, "R7");
    send(3'd3, 0, 0, 1, 6'd0, 8'h62, 6'd31, 16'hC000, "R7");
    send(3'd1, 0, 0, 0, 6'd0, 8'h63, 6'd31, 16'hD000, "R7");
    // R9 back-to-back same slot
    for (int k = 0; k < 6; k++)
      send(3'd1, 0, 0, 1'(k), 6'd0, 8'(8'h70 + k), 6'd40, 16'(16'hE000 + k), "R9");
    send(3'd2, 0, 0, 0, 6'd0, 8'h78, 6'd41, 16'hF000, "R9");
    send(3'd2, 0, 0, 1, 6'd0, 8'h79, 6'd41, 16'hF001, "R9");
    send(3'd3, 0, 0, 1, 6'd0, 8'h7A, 6'd41, 16'hF002, "R9");
    send(3'd2, 0, 0, 0, 6'd0, 8'h7B, 6'd41, 16'hF003, "R9");

    // R10 random stream under back-pressure on few slots
    rand_ready = 1'b1;
    for (int n = 0; n < 400; n++) begin
      logic [2:0] m; logic rel, iw, pt; logic [5:0] fp, off, s;
      m   = 3'($urandom_range(0, 7));
      rel = 1'($urandom_range(0, 1));
      iw  = 1'($urandom_range(0, 1));
      pt  = 1'($urandom_range(0, 1));
      fp  = 6'($urandom_range(0, 3));
      off = 6'($urandom_range(0, 3));
      s   = slot_of(rel, fp, off);
      if ((m == 3'd3 || (m == 3'd4 && !iw)) && !m_wr[s]) m = 3'd1;
      send(m, rel, iw, pt, fp, 8'(n), off, 16'($urandom), "R10");
    end
    rand_ready = 1'b0;
    for (int w = 0; w < 50 && q_l.size() != 0; w++) @(negedge clk);
    repeat (3) @(negedge clk);
    check(q_l.size() == 0, "R10", "pending results", q_l.size(), 0);
    check(out_valid == 1'b0, "R3", "idle out_valid", int'(out_valid), 0);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule